// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block runs on the system clock and produces a one-cycle clock-enable pulse for the slower peripheral bus. A 2-bit ratio select sets the pulse rate. Peripherals on the divided bus advance only in cycles where the enable is high. Logic clocked straight from the system clock, such as interrupt, DMA or cache logic, does not use the enable, so ratio changes do not affect it.

The block also paces CPU reads aimed at the divided bus. A read request is held until the next enable pulse, and the ready strobe is raised in that pulse cycle. The stall is therefore variable: it depends on the selected ratio and on the phase of the request against the divided clock. A new ratio is applied only when the current divided period ends, so an enable period is never cut short.

Top module: `pbus_clkdiv`

## Requirements
- R1: The ratio select encodes the ratio as 00 = 1:1, 01 = 1:2, 10 = 1:4 and 11 = 1:8. Once a ratio N is in force, `pbClkEn` is high for one cycle in every N system cycles.
- R2: At 1:1, `pbClkEn` is high in every cycle and a read is ready in the same cycle it is requested.
- R3: A read requested in a cycle where `pbClkEn` is low is held pending. It completes in the next cycle where `pbClkEn` is high, after a wait of 1 to N-1 cycles (at 1:8, 1 to 7).
- R4: A read requested in a cycle where `pbClkEn` is high completes in that same cycle, with no stall.
- R5: `rdReady` is high only in cycles where `pbClkEn` is high. It is high for exactly one cycle per request and stays low afterwards until a new request arrives.
- R6: A further request made while a read is already pending has no effect. The pending read completes with a single `rdReady` pulse.
- R7: A change of the ratio select takes effect only at the end of the running divided period. The gap up to the next pulse always follows the old ratio, and periods after that follow the new one.
- R8: Reset clears the counter, selects 1:1 and drops any pending read. In the first cycle after reset is released, `pbClkEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 2 | Ratio select (00 1:1, 01 1:2, 10 1:4, 11 1:8) |
| rdReq | input | 1 | CPU read request toward the divided bus, one cycle per request |
| pbClkEn | output | 1 | Peripheral-bus clock enable, one system cycle wide |
| rdReady | output | 1 | Read completion strobe back to the CPU |

## Verification
Every ratio is tried, and at each one the read request is issued at every phase of the divided period. This separates the zero-stall case (a request landing on a pulse) from every length of held stall, and it shows whether the wait counts toward the next pulse rather than a fixed delay. A doubled request within one period shows whether requests merge or queue. Ratio changes made mid-period, from slow to fast and from fast to slow, tell deferred loading apart from immediate loading. A reset released with the slowest ratio selected shows that the first cycle still runs at 1:1.

// File: rtl/pbus_clkdiv_pkg.sv
package pbus_clkdiv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntAdv;   // step the phase counter
    logic cntWrap;  // return the phase counter to zero
    logic selLoad;  // take a new ratio select
  } divStrobe_t;

endpackage

// File: rtl/pbus_clkdiv_dp.sv
module pbus_clkdiv_dp
  import pbus_clkdiv_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  divStrobe_t       strb,
  output logic             termHit
);

  localparam int NUM_SEL = 2 ** SEL_W;
  localparam int CNT_W   = (NUM_SEL > 1) ? NUM_SEL - 1 : 1;

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] actSel;
  logic [CNT_W-1:0] limTab [NUM_SEL];

  // Terminal count for each ratio: 2**g - 1
  for (genvar g = 0; g < NUM_SEL; g++) begin : gLim
    assign limTab[g] = CNT_W'((1 << g) - 1);
  end

  assign termHit = (cnt == limTab[actSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      actSel <= '0;
    end else begin
      if (strb.cntWrap)     cnt <= '0;
      else if (strb.cntAdv) cnt <= cnt + 1'b1;
      if (strb.selLoad)     actSel <= divSel;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limTab[actSel]);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selLoad |=> $stable(actSel));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWrap |=> (cnt == '0));

endmodule

// File: rtl/pbus_clkdiv_ctrl.sv
module pbus_clkdiv_ctrl
  import pbus_clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       termHit,
  input  logic       rdReq,
  output divStrobe_t strb,
  output logic       pbClkEn,
  output logic       rdReady
);

  logic pending;

  always_comb begin
    strb.cntWrap = termHit;
    strb.cntAdv  = !termHit;
    strb.selLoad = termHit;
  end

  assign pbClkEn = termHit;
  assign rdReady = termHit && (rdReq || pending);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pending <= 1'b0;
    else if (rdReady)          pending <= 1'b0;
    else if (rdReq)            pending <= 1'b1;
  end

  // R5
  rdy_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> pbClkEn);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !termHit) |=> pending);

  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !pending);

endmodule

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv
  import pbus_clkdiv_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             rdReq,
  output logic             pbClkEn,
  output logic             rdReady
);

  divStrobe_t strb;
  logic       termHit;

  pbus_clkdiv_dp #(.SEL_W(SEL_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .divSel  (divSel),
    .strb    (strb),
    .termHit (termHit)
  );

  pbus_clkdiv_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .termHit (termHit),
    .rdReq   (rdReq),
    .strb    (strb),
    .pbClkEn (pbClkEn),
    .rdReady (rdReady)
  );

endmodule

// File: tb/pbus_clkdiv_tb_top.sv
module pbus_clkdiv_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] divSel;
  logic       rdReq;
  logic       pbClkEn;
  logic       rdReady;

  int  passCnt = 0;
  int  failCnt = 0;
  logic en, rdy;

  always #4 clk = ~clk;

  pbus_clkdiv dut_i (
    .clk(clk), .rstN(rstN), .divSel(divSel),
    .rdReq(rdReq), .pbClkEn(pbClkEn), .rdReady(rdReady)
  );

  task automatic chk(input string req, input int act, input int exp);
    if (act == exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns later
  task automatic step(input logic req);
    @(negedge clk);
    rdReq = req;
    #1;
    en  = pbClkEn;
    rdy = rdReady;
  endtask

  task automatic findEn();
    for (int i = 0; i < 20; i++) begin
      step(1'b0);
      if (en) return;
    end
  endtask

  // cycles until the next enable, counting the cycle of the enable
  task automatic gapToEn(output int gap);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b0);
      gap++;
      if (en) return;
    end
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    int gap, lat, extra, n;
    rstN = 1'b0; divSel = 2'd3; rdReq = 1'b0;
    repeat (3) @(negedge clk);
    // R8: first cycle after release runs at 1:1 even with 1:8 selected
    @(negedge clk);
    rstN  = 1'b1;
    rdReq = 1'b1;
    #1;
    chk("R8 enable after reset", pbClkEn, 1);
    chk("R8 read ready after reset", rdReady, 1);
    gapToEn(gap);
    chk("R8 then 1:8 applied", gap, 8);

    for (int sel = 0; sel < 4; sel++) begin
      n = 1 << sel;
      divSel = 2'(sel);
      repeat (20) step(1'b0);
      findEn();
      for (int p = 0; p < 3; p++) begin
        gapToEn(gap);
        chk("R1 period", gap, n);
      end
      if (sel == 0) begin
        extra = 0;
        repeat (10) begin step(1'b0); if (!en) extra++; end
        chk("R2 enable every cycle", extra, 0);
      end
      for (int k = 0; k < n; k++) begin
        findEn();
        for (int i = 1; i < n + k; i++) step(1'b0);
        step(1'b1);
        lat = 0;
        while (!rdy && lat < 20) begin step(1'b0); lat++; end
        if (k == 0) chk(sel == 0 ? "R2 no stall" : "R4 no stall", lat, 0);
        else        chk("R3 stall", lat, n - k);
        chk("R5 ready with enable", en, 1);
        extra = 0;
        repeat (n + 2) begin step(1'b0); if (rdy) extra++; end
        chk("R5 single ready", extra, 0);
      end
    end

    // R6: two requests in one 1:8 period merge
    divSel = 2'd3;
    repeat (20) step(1'b0);
    findEn();
    step(1'b0);
    step(1'b1);
    step(1'b0);
    extra = rdy ? 1 : 0;
    step(1'b1);
    if (rdy) extra++;
    lat = 0;
    while (!rdy && lat < 20) begin step(1'b0); lat++; end
    chk("R6 pending completes on edge", lat, 4);
    repeat (12) begin step(1'b0); if (rdy) extra++; end
    chk("R6 one ready for merged requests", extra, 0);

    // R7: slow-to-fast change mid period keeps the old period
    findEn();
    step(1'b0);
    divSel = 2'd0;
    gapToEn(gap);
    chk("R7 old period kept", gap, 7);
    extra = 0;
    repeat (5) begin step(1'b0); if (!en) extra++; end
    chk("R7 new ratio 1:1", extra, 0);
    // R7: fast-to-slow change
    divSel = 2'd2;
    gapToEn(gap);
    chk("R7 new ratio 1:4", gap, 4);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule